// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave half of a byte-addressed serial memory of 4096 locations sitting on a two-wire bus. It does not see the raw bus wires. A separate condition detector feeds it single-cycle strobes: START, STOP, clock rising edge (the data line is sampled there) and clock falling edge (the slave may change its drive there). The block answers with one open-drain style output that asks for the data line to be pulled low.

A master selects the device with a control byte carrying a fixed device code, three strap bits and a read/write flag. Two address bytes follow. Writes go into a 32-byte page buffer that is programmed into the array when STOP is seen, and a busy interval then follows. During that interval the device stays silent. Reads return data most significant bit first and keep advancing through the array for as long as the master acknowledges. A random read is a write that stops after the address bytes, followed by a repeated START and a read control byte.

Top module: `eeprom_slave`

## Requirements
- R1: After reset, `sda_pull` and `busy` are both 0.
- R2: A control byte is bits 7..4 = 1010, bits 3..1 equal to `strap`, bit 0 = 1 for read. A matching byte is acknowledged. Any other byte is not acknowledged, and the block then leaves the line released until the next START.
- R3: An acknowledge is `sda_pull` = 1. It is set at the falling-edge strobe that follows the eighth rising-edge strobe of a byte and held until the next falling-edge strobe. `sda_pull` changes only at falling-edge, START or STOP strobes.
- R4: Two address bytes follow a write control byte, high byte first. Only bits 11..0 of the pair form the address, so bits 7..4 of the high byte are ignored.
- R5: Data bytes of a write go into a 32-location page buffer. The low five address bits wrap within the page. A later byte for the same location replaces an earlier one, so 34 bytes leave the first two locations holding bytes 33 and 34.
- R6: The buffered bytes are programmed only at a STOP that closes a write carrying at least one data byte. A repeated START discards them.
- R7: `busy` is 1 for exactly WR_CYCLES clock cycles, starting with the cycle after a programming STOP. A control byte whose last bit arrives while `busy` is 1 gets no acknowledge.
- R8: When `wp` is 1 at the STOP, the address and data bytes of the write have still been acknowledged, but no programming happens and `busy` stays 0.
- R9: After a read control byte, the block sends the byte at the current address, most significant bit first, with `sda_pull` = inverse of the bit, set at each falling-edge strobe.
- R10: A master acknowledge (line low at the ninth rising edge) advances the address by one, wrapping from 4095 to 0, and the next byte is sent.
- R11: A master non-acknowledge ends the read. The line stays released and the address is not advanced.
- R12: A START or STOP in the middle of a byte drops the partial byte. START goes back to waiting for a control byte. STOP goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_evt | input | 1 | START (or repeated START) strobe |
| stop_evt | input | 1 | STOP strobe |
| scl_rise | input | 1 | Clock rising-edge strobe, sample `sda_in` |
| scl_fall | input | 1 | Clock falling-edge strobe, drive may change |
| sda_in | input | 1 | Data line level |
| strap | input | 3 | Device select straps |
| wp | input | 1 | Write protect |
| sda_pull | output | 1 | 1 pulls the data line low |
| busy | output | 1 | Programming interval in progress |

## Verification
Two functions can meet in one clock: the write timer's final count and the acknowledge decision on the last bit of a control byte. The bench holds the control byte just before its eighth rising strobe until the modelled timer reads exactly one, then releases it. The byte must then go unacknowledged. A second run aims the strobe at the first cycle after the timer runs out, and that byte must be acknowledged. A reference model of the timer and of the expected line drive is compared on every clock, so a decision that is off by one cycle in either direction shows up.

// File: rtl/eeprom_slave.sv
`timescale 1ns/1ps
module eeprom_slave #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 400,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_evt,
  input  logic       stop_evt,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_in,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_pull,
  output logic       busy
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TW    = $clog2(WR_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_CTRL, S_AHI, S_ALO, S_WDAT, S_RDAT} st_t;
  st_t st;

  logic [3:0]        bitcnt;
  logic [6:0]        sh;
  logic [7:0]        tx, ahi;
  logic [ADDR_W-1:0] addr;
  logic              ack_q, rd_lead;
  logic [PAGE-1:0]   pmask;
  logic [TW-1:0]     tmr;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        pbuf [PAGE];

  wire [7:0]        rx       = {sh, sda_in};
  wire [ADDR_W-1:0] addr_nx  = addr + ADDR_W'(1);
  wire              ctrl_hit = rx[7:4] == DEV_CODE && rx[3:1] == strap && !busy;
  wire              bit_go   = scl_rise && !start_evt && !stop_evt && st != S_IDLE;
  wire              byte_end = bit_go && bitcnt == 4'd7;
  wire              take_dat = byte_end && st == S_WDAT;
  wire              commit   = stop_evt && st == S_WDAT && |pmask && !wp;

  assign busy = tmr != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) tmr <= '0;
    else if (commit) tmr <= TW'(WR_CYCLES);
    else if (busy) tmr <= tmr - TW'(1);
  end

  always_ff @(posedge clk) begin
    if (take_dat) pbuf[addr[PAGE_W-1:0]] <= rx;
    if (commit)
      for (int i = 0; i < PAGE; i++)
        if (pmask[i]) mem[{addr[ADDR_W-1:PAGE_W], PAGE_W'(i)}] <= pbuf[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; sh <= '0; tx <= '0; ahi <= '0; addr <= '0;
      ack_q <= 1'b0; rd_lead <= 1'b0; pmask <= '0; sda_pull <= 1'b0;
    end else if (start_evt || stop_evt) begin
      st <= start_evt ? S_CTRL : S_IDLE;
      bitcnt <= '0; ack_q <= 1'b0; rd_lead <= 1'b0; pmask <= '0; sda_pull <= 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_fall) begin
        if (bitcnt == 4'd8) sda_pull <= ack_q;
        else if (st == S_RDAT) sda_pull <= ~tx[3'd7 - bitcnt[2:0]];
        else sda_pull <= 1'b0;
      end
      if (scl_rise) begin
        if (bitcnt != 4'd8) begin
          sh <= rx[6:0];
          bitcnt <= bitcnt + 4'd1;
          if (bitcnt == 4'd7) begin
            case (st)
              S_CTRL: begin
                ack_q <= ctrl_hit;
                if (!ctrl_hit) st <= S_IDLE;
                else if (rx[0]) begin st <= S_RDAT; rd_lead <= 1'b1; tx <= mem[addr]; end
                else st <= S_AHI;
              end
              S_AHI:  begin ahi <= rx; ack_q <= 1'b1; st <= S_ALO; end
              S_ALO:  begin addr <= ADDR_W'({ahi, rx}); ack_q <= 1'b1; st <= S_WDAT; pmask <= '0; end
              S_WDAT: begin
                pmask[addr[PAGE_W-1:0]] <= 1'b1;
                addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + PAGE_W'(1);
                ack_q <= 1'b1;
              end
              default: ack_q <= 1'b0;
            endcase
          end
        end else begin
          bitcnt <= '0;
          if (st == S_RDAT) begin
            if (rd_lead) rd_lead <= 1'b0;
            else if (sda_in) st <= S_IDLE;
            else begin addr <= addr_nx; tx <= mem[addr_nx]; end
          end
        end
      end
    end
  end

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !sda_pull);
  // R7
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(stop_evt));
  // R3
  pull_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall && !start_evt && !stop_evt) |=> $stable(sda_pull));
  // R12
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n) stop_evt |=> !sda_pull);
  // R8
  wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n) (stop_evt && wp && !busy) |=> !busy);
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE) |-> !sda_pull);
endmodule

// File: tb/eeprom_slave_tb.sv
`timescale 1ns/1ps
module eeprom_slave_tb_top;
  localparam int WR = 120;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start_evt = 0, stop_evt = 0, scl_rise = 0, scl_fall = 0, sda_in = 1, wp = 0;
  logic [2:0] strap = 3'b101;
  logic sda_pull, busy;

  eeprom_slave #(.WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_in(sda_in), .strap(strap),
    .wp(wp), .sda_pull(sda_pull), .busy(busy));

  int compared = 0, mismatched = 0;
  string req = "R1";
  logic exp_pull = 1'b0;
  int mtmr = 0;
  bit commit_flag = 0, in_wdata = 0, done = 0;
  logic [7:0] ref_mem [4096];
  logic [7:0] pend [int];
  int maddr = 0;
  logic [7:0] mhi = 0;

  function automatic void chk(string r, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endfunction

  initial forever begin
    @(posedge clk); #1;
    if (rst_n) begin
      if (commit_flag) begin mtmr = WR; commit_flag = 0; end
      else if (mtmr > 0) mtmr--;
      chk(req, "sda_pull", sda_pull, exp_pull);
      chk("R7", "busy", busy, mtmr != 0);
    end
  end

  task automatic p_fall(input logic e);
    @(negedge clk); scl_fall = 1; exp_pull = e;
    @(negedge clk); scl_fall = 0;
  endtask
  task automatic p_rise(input logic v);
    @(negedge clk); scl_rise = 1; sda_in = v;
    @(negedge clk); scl_rise = 0;
  endtask
  task automatic do_start();
    @(negedge clk); start_evt = 1; exp_pull = 0; pend.delete(); in_wdata = 0;
    @(negedge clk); start_evt = 0;
  endtask
  task automatic do_stop();
    @(negedge clk); stop_evt = 1; exp_pull = 0;
    if (in_wdata && pend.size() > 0 && !wp) begin
      foreach (pend[k]) ref_mem[k] = pend[k];
      commit_flag = 1;
    end
    pend.delete(); in_wdata = 0;
    @(negedge clk); stop_evt = 0;
  endtask
  task automatic wait_ready();
    while (mtmr != 0) @(negedge clk);
  endtask
  task automatic bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin p_fall(0); p_rise(b[i]); end
  endtask

  task automatic send_ctrl(input logic [2:0] a, input logic rw, input int wait_t, output bit acked);
    logic [7:0] b = {4'b1010, a, rw};
    bits(b, 7);
    p_fall(0);
    if (wait_t >= 0) while (mtmr != wait_t + 1) @(negedge clk);
    @(negedge clk);
    acked = (a == strap) && (mtmr == 0);
    scl_rise = 1; sda_in = b[0];
    @(negedge clk); scl_rise = 0;
    p_fall(acked);
    chk(req, "ctrl ack", sda_pull, acked);
    p_rise(!acked);
  endtask

  task automatic send_byte(input logic [7:0] b, input int kind);
    bits(b, 8);
    p_fall(1);
    chk(req, "byte ack", sda_pull, 1);
    p_rise(0);
    if (kind == 0) mhi = b;
    else if (kind == 1) begin maddr = {mhi[3:0], b}; in_wdata = 1; end
    else begin pend[maddr] = b; maddr = (maddr & ~31) | ((maddr + 1) & 31); end
  endtask

  task automatic read_byte(input bit mack, input string r);
    logic [7:0] e = ref_mem[maddr];
    logic [7:0] got;
    for (int i = 7; i >= 0; i--) begin
      p_fall(~e[i]);
      got[i] = ~sda_pull;
      p_rise(e[i]);
    end
    chk(r, "read byte", got, e);
    p_fall(0);
    p_rise(!mack);
    if (mack) maddr = (maddr + 1) % 4096;
  endtask

  task automatic set_addr(input logic [7:0] hi, input logic [7:0] lo);
    bit a;
    do_start(); send_ctrl(strap, 0, -1, a);
    send_byte(hi, 0); send_byte(lo, 1);
  endtask

  task automatic rd_seq(input int n, input string r);
    bit a;
    do_start(); send_ctrl(strap, 1, -1, a);
    chk(r, "read ctrl ack", a, 1);
    for (int i = 0; i < n; i++) read_byte(i != n - 1, r);
    do_stop();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++; compared++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    bit a;
    repeat (3) @(negedge clk);
    chk("R1", "reset sda_pull", sda_pull, 0);
    chk("R1", "reset busy", busy, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    req = "R2";
    do_start(); send_ctrl(3'b010, 0, -1, a);
    chk("R2", "foreign strap ack", a, 0);
    bits(8'h00, 8); p_fall(0); p_rise(0);
    do_stop();

    req = "R4";
    set_addr(8'hF1, 8'h23); send_byte(8'h5C, 2); do_stop();
    chk("R7", "busy after commit", busy, 1);
    req = "R7";
    do_start(); send_ctrl(strap, 0, -1, a);
    chk("R7", "no ack while busy", a, 0);
    do_stop();
    do_start(); send_ctrl(strap, 0, 1, a);
    chk("R7", "last busy cycle nack", a, 0);
    do_stop(); wait_ready();

    req = "R7";
    set_addr(8'h00, 8'h60); send_byte(8'h3A, 2); do_stop();
    do_start(); send_ctrl(strap, 0, 0, a);
    chk("R7", "first free cycle ack", a, 1);
    do_stop(); wait_ready();

    req = "R9";
    set_addr(8'h01, 8'h23); rd_seq(1, "R9");
    set_addr(8'h00, 8'h60); rd_seq(1, "R9");

    req = "R5";
    set_addr(8'h03, 8'hFC);
    for (int i = 0; i < 6; i++) send_byte(8'h10 + 8'(i), 2);
    do_stop(); wait_ready();
    set_addr(8'h03, 8'hE0); rd_seq(2, "R5");
    set_addr(8'h03, 8'hFC); rd_seq(4, "R10");

    req = "R5";
    set_addr(8'h00, 8'h40);
    for (int i = 0; i < 34; i++) send_byte(8'h80 + 8'(i), 2);
    do_stop(); wait_ready();
    set_addr(8'h00, 8'h40); rd_seq(4, "R5");

    req = "R10";
    set_addr(8'h0F, 8'hFE); send_byte(8'hC1, 2); send_byte(8'hC2, 2); do_stop(); wait_ready();
    set_addr(8'h00, 8'h00); send_byte(8'hD1, 2); send_byte(8'hD2, 2); do_stop(); wait_ready();
    set_addr(8'h0F, 8'hFE); rd_seq(4, "R10");

    req = "R8";
    wp = 1;
    set_addr(8'h00, 8'h40); send_byte(8'hAA, 2); do_stop();
    repeat (4) @(negedge clk);
    chk("R8", "no busy under wp", busy, 0);
    wp = 0;
    set_addr(8'h00, 8'h40); rd_seq(1, "R8");

    req = "R6";
    set_addr(8'h00, 8'h41); send_byte(8'h22, 2);
    do_start(); send_ctrl(strap, 0, -1, a); do_stop();
    repeat (4) @(negedge clk);
    chk("R6", "discarded page no busy", busy, 0);
    set_addr(8'h00, 8'h41); rd_seq(1, "R6");

    req = "R12";
    set_addr(8'h00, 8'h42); do_stop();
    do_start(); send_ctrl(strap, 0, -1, a); send_byte(8'h00, 0);
    bits(8'h60, 4); do_stop();
    repeat (4) @(negedge clk);
    chk("R12", "aborted address no busy", busy, 0);
    do_start(); bits(8'hA0, 3);
    rd_seq(2, "R12");

    req = "R11";
    set_addr(8'h00, 8'h60);
    do_start(); send_ctrl(strap, 1, -1, a);
    read_byte(0, "R11");
    p_fall(0); chk("R11", "released after nack", sda_pull, 0);
    p_rise(1); p_fall(0);
    do_stop();
    rd_seq(1, "R11");

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule